// File: doc/BRIEF.md
# Lockable Strap-Override Register Bank

This block holds three 32-bit memory-mapped registers that decide which 14-bit configuration word a downstream strap-message sender transmits. One register carries a lock bit, one carries a source-select bit, and one carries the programmed strap value. The word leaving the block is either a built-in default, set by a parameter, or the programmed value, and the select bit chooses between them. Setting the lock bit freezes all three registers, the lock register included. The only way to reopen the bank is a warm reset.

The lock bit and the payload (the select bit and the strap value) are cleared by two different reset inputs. The warm reset clears only the lock. The resume reset clears only the payload. Both resets assert asynchronously and release through a two-stage synchronizer. Because of this split, a resume reset can clear the payload while the bank stays locked, and the payload then stays at zero until a warm reset.

The design is built around two small state machines. The lock machine has states LK_OPEN and LK_SEALED. Its only transition is SEAL, from LK_OPEN to LK_SEALED, and a warm reset returns it to LK_OPEN. The source machine has states SRC_BUILTIN and SRC_PROGRAMMED, with transitions ADOPT (to SRC_PROGRAMMED) and REVERT (to SRC_BUILTIN). A resume reset returns it to SRC_BUILTIN. Reads are combinational from the address, with no handshake.

Top module: `strap_ovr_bank`

## Requirements
- R1: After both resets, every register reads zero and `strap_word` equals the default parameter, which is 14'h0A5C unless overridden.
- R2: A write at offset 0xF0 with bit 0 set while the bank is open makes 0xF0 read 1 from the next cycle on.
- R3: While the lock bit is 1, writes to 0xF0, 0xF4 and 0xF8 leave every register unchanged, and the lock bit cannot be cleared by a write.
- R4: Bit 0 of offset 0xF4 selects the output word: `strap_word` is the default when it is 0, and bits 13:0 of 0xF8 when it is 1.
- R5: Offset 0xF8 stores the written bits 13:0. Bits 31:14 of 0xF8 and bits 31:1 of 0xF0 and 0xF4 always read zero, and writing them has no effect.
- R6: The warm reset clears the lock bit and leaves the select bit and the strap value untouched.
- R7: The resume reset clears the select bit and the strap value and leaves the lock bit untouched. Once cleared under a lock, the payload stays unwritable until a warm reset.
- R8: Reads return current contents whatever the lock state. Any address other than 0xF0, 0xF4 and 0xF8 (for example 0x00, 0xF1 and 0xFC) reads zero, and writes to such addresses change nothing.
- R9: A cycle with `wr_en` low changes no register.
- R10: A write presented while a reset is asserted, or on the first clock edge after the reset input rises, is dropped by the registers of that reset's domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| warm_rst_n | input | 1 | Warm reset, active low, clears the lock bit |
| rsm_rst_n | input | 1 | Resume reset, active low, clears select and strap value |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| strap_word | output | 14 | Configuration word handed to the message sender |

## Verification
The bench goes after the lock sealing itself. A design that gated only the sibling registers would let a later write of 0 reopen the bank. It also checks each reset domain in isolation. A design that put the lock or the payload in the wrong domain would either lose the programmed word on a warm reset or unlock on a resume reset. The bench checks the locked-and-zeroed state after a resume reset under lock, where a design that let the reset reopen writes would accept new data. Further cases cover reserved and unmapped addresses, which a sloppy decode would alias onto real registers, and writes in the reset-release cycle, which a design without the synchronizer would accept one edge early.

// File: rtl/strap_ovr_pkg.sv
`timescale 1ns/1ps
package strap_ovr_pkg;

    // Lock machine states
    typedef enum logic [0:0] {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    // Output word source states
    typedef enum logic [0:0] {
        SRC_BUILTIN    = 1'b0,
        SRC_PROGRAMMED = 1'b1
    } src_state_e;

    // Decoded register target
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LOCK = 2'd1,
        TGT_CTRL = 2'd2,
        TGT_SDAT = 2'd3
    } reg_tgt_e;

endpackage

// File: rtl/strap_rst_sync.sv
`timescale 1ns/1ps
module strap_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    generate
        if (STAGES < 2) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) q <= 1'b0;
                else         q <= 1'b1;
            end
            assign srst_n = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) q <= '0;
                else         q <= {q[STAGES-2:0], 1'b1};
            end
            assign srst_n = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/strap_lock_fsm.sv
`timescale 1ns/1ps
module strap_lock_fsm
    import strap_ovr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_req,
    output logic locked
);
    lock_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    // Next state: SEAL is the only transition; only reset leaves LK_SEALED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (seal_req) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    // Outputs
    always_comb begin
        locked = 1'b0;
        unique case (state_q)
            LK_OPEN:   locked = 1'b0;
            LK_SEALED: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/strap_payload_regs.sv
`timescale 1ns/1ps
module strap_payload_regs
    import strap_ovr_pkg::*;
#(
    parameter int               STRAP_W       = 14,
    parameter logic [STRAP_W-1:0] STRAP_DEFAULT = 14'h0A5C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open,
    input  logic               wr_ctrl,
    input  logic               wr_sdat,
    input  logic               wbit0,
    input  logic [STRAP_W-1:0] wval,
    output logic               src_prog,
    output logic [STRAP_W-1:0] sdat_q,
    output logic [STRAP_W-1:0] strap_word
);
    src_state_e src_q, src_d;
    logic [STRAP_W-1:0] sdat_d;

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= SRC_BUILTIN;
            sdat_q <= '0;
        end else begin
            src_q  <= src_d;
            sdat_q <= sdat_d;
        end
    end

    // Next state: ADOPT and REVERT, both only while the bank is open
    always_comb begin
        src_d  = src_q;
        sdat_d = sdat_q;
        if (open && wr_sdat) sdat_d = wval;
        unique case (src_q)
            SRC_BUILTIN:    if (open && wr_ctrl && wbit0)  src_d = SRC_PROGRAMMED;
            SRC_PROGRAMMED: if (open && wr_ctrl && !wbit0) src_d = SRC_BUILTIN;
        endcase
    end

    // Outputs
    always_comb begin
        src_prog   = 1'b0;
        strap_word = STRAP_DEFAULT;
        unique case (src_q)
            SRC_BUILTIN: begin
                src_prog   = 1'b0;
                strap_word = STRAP_DEFAULT;
            end
            SRC_PROGRAMMED: begin
                src_prog   = 1'b1;
                strap_word = sdat_q;
            end
        endcase
    end
endmodule

// File: rtl/strap_rd_mux.sv
`timescale 1ns/1ps
module strap_rd_mux
    import strap_ovr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int STRAP_W = 14
) (
    input  reg_tgt_e           tgt,
    input  logic               locked,
    input  logic               src_prog,
    input  logic [STRAP_W-1:0] sdat_q,
    output logic [DATA_W-1:0]  rdata
);
    localparam int PAD_W = DATA_W - STRAP_W;

    always_comb begin
        rdata = '0;
        unique case (tgt)
            TGT_NONE: rdata = '0;
            TGT_LOCK: rdata = {{(DATA_W-1){1'b0}}, locked};
            TGT_CTRL: rdata = {{(DATA_W-1){1'b0}}, src_prog};
            TGT_SDAT: rdata = {{PAD_W{1'b0}}, sdat_q};
        endcase
    end
endmodule

// File: rtl/strap_ovr_bank.sv
`timescale 1ns/1ps
module strap_ovr_bank
    import strap_ovr_pkg::*;
#(
    parameter int                 ADDR_W        = 8,
    parameter int                 DATA_W        = 32,
    parameter int                 STRAP_W       = 14,
    parameter int                 SYNC_STAGES   = 2,
    parameter logic [STRAP_W-1:0] STRAP_DEFAULT = 14'h0A5C,
    parameter logic [ADDR_W-1:0]  LOCK_OFS      = 8'hF0,
    parameter logic [ADDR_W-1:0]  CTRL_OFS      = 8'hF4,
    parameter logic [ADDR_W-1:0]  SDAT_OFS      = 8'hF8
) (
    input  logic               clk,
    input  logic               warm_rst_n,
    input  logic               rsm_rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [STRAP_W-1:0] strap_word
);
    logic     wrst_s, rrst_s;
    logic     locked, src_prog;
    logic [STRAP_W-1:0] sdat_q;
    reg_tgt_e tgt;
    logic     unused_wdata_hi;

    // Reserved write bits are dropped
    assign unused_wdata_hi = ^wdata[DATA_W-1:STRAP_W];

    strap_rst_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(clk), .arst_n(warm_rst_n), .srst_n(wrst_s)
    );
    strap_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk(clk), .arst_n(rsm_rst_n), .srst_n(rrst_s)
    );

    // Address decode on the full offset
    always_comb begin
        if      (addr == LOCK_OFS) tgt = TGT_LOCK;
        else if (addr == CTRL_OFS) tgt = TGT_CTRL;
        else if (addr == SDAT_OFS) tgt = TGT_SDAT;
        else                       tgt = TGT_NONE;
    end

    strap_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (wrst_s),
        .seal_req (wr_en && (tgt == TGT_LOCK) && wdata[0]),
        .locked   (locked)
    );

    strap_payload_regs #(
        .STRAP_W(STRAP_W), .STRAP_DEFAULT(STRAP_DEFAULT)
    ) u_pay (
        .clk        (clk),
        .rst_n      (rrst_s),
        .open       (!locked),
        .wr_ctrl    (wr_en && (tgt == TGT_CTRL)),
        .wr_sdat    (wr_en && (tgt == TGT_SDAT)),
        .wbit0      (wdata[0]),
        .wval       (wdata[STRAP_W-1:0]),
        .src_prog   (src_prog),
        .sdat_q     (sdat_q),
        .strap_word (strap_word)
    );

    strap_rd_mux #(.DATA_W(DATA_W), .STRAP_W(STRAP_W)) u_rd (
        .tgt      (tgt),
        .locked   (locked),
        .src_prog (src_prog),
        .sdat_q   (sdat_q),
        .rdata    (rdata)
    );
endmodule

// File: rtl/strap_ovr_chk.sv
`timescale 1ns/1ps
module strap_ovr_chk #(
    parameter int                 ADDR_W        = 8,
    parameter int                 DATA_W        = 32,
    parameter int                 STRAP_W       = 14,
    parameter logic [STRAP_W-1:0] STRAP_DEFAULT = 14'h0A5C,
    parameter logic [ADDR_W-1:0]  LOCK_OFS      = 8'hF0,
    parameter logic [ADDR_W-1:0]  CTRL_OFS      = 8'hF4,
    parameter logic [ADDR_W-1:0]  SDAT_OFS      = 8'hF8
) (
    input logic               clk,
    input logic               wrst_s,
    input logic               rrst_s,
    input logic [ADDR_W-1:0]  addr,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic [STRAP_W-1:0] strap_word,
    input logic               locked,
    input logic               src_prog,
    input logic [STRAP_W-1:0] sdat_q
);
    a_r2_lock_set: assert property (@(posedge clk) disable iff (!wrst_s)
        (wr_en && addr == LOCK_OFS && wdata[0]) |=> locked);

    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!wrst_s)
        locked |=> locked);

    a_r3_payload_frozen: assert property (@(posedge clk) disable iff (!rrst_s || !wrst_s)
        locked |=> ($stable(src_prog) && $stable(sdat_q)));

    a_r4_builtin_word: assert property (@(posedge clk) disable iff (!rrst_s)
        (addr == CTRL_OFS && rdata[0] == 1'b0) |-> (strap_word == STRAP_DEFAULT));

    a_r5_sdat_reserved: assert property (@(posedge clk) disable iff (!rrst_s)
        (addr == SDAT_OFS) |-> (rdata[DATA_W-1:STRAP_W] == '0));

    a_r7_lock_survives_rsm: assert property (@(posedge clk) disable iff (!wrst_s)
        (locked && !rrst_s) |=> locked);

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!wrst_s)
        (addr != LOCK_OFS && addr != CTRL_OFS && addr != SDAT_OFS) |-> (rdata == '0));
endmodule

bind strap_ovr_bank strap_ovr_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRAP_W(STRAP_W),
    .STRAP_DEFAULT(STRAP_DEFAULT),
    .LOCK_OFS(LOCK_OFS), .CTRL_OFS(CTRL_OFS), .SDAT_OFS(SDAT_OFS)
) u_chk (
    .clk(clk), .wrst_s(wrst_s), .rrst_s(rrst_s), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .strap_word(strap_word),
    .locked(locked), .src_prog(src_prog), .sdat_q(sdat_q)
);

// File: tb/tb_strap_ovr_bank.sv
`timescale 1ns/1ps
module tb_strap_ovr_bank;
    localparam logic [13:0] DEF = 14'h0A5C;
    localparam int SYNC = 2;

    logic        clk;
    logic        warm_rst_n, rsm_rst_n;
    logic [7:0]  addr;
    logic        wr_en;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [13:0] strap_word;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    strap_ovr_bank dut (
        .clk(clk), .warm_rst_n(warm_rst_n), .rsm_rst_n(rsm_rst_n),
        .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .strap_word(strap_word)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Behavioural reference model
    int m_lock, m_sel, m_data, wcnt, rcnt;

    always @(posedge clk or negedge warm_rst_n) begin
        if (!warm_rst_n) begin
            m_lock <= 0; wcnt <= 0;
        end else begin
            if (wcnt >= SYNC && wr_en && addr == 8'hF0 && wdata[0]) m_lock <= 1;
            if (wcnt < SYNC) wcnt <= wcnt + 1;
        end
    end

    always @(posedge clk or negedge rsm_rst_n) begin
        if (!rsm_rst_n) begin
            m_sel <= 0; m_data <= 0; rcnt <= 0;
        end else begin
            if (rcnt >= SYNC && wr_en && m_lock == 0) begin
                if (addr == 8'hF4) m_sel  <= int'(wdata[0]);
                if (addr == 8'hF8) m_data <= int'(wdata[13:0]);
            end
            if (rcnt < SYNC) rcnt <= rcnt + 1;
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        if (a == 8'hF0)      return (m_lock != 0) ? 32'd1 : 32'd0;
        else if (a == 8'hF4) return (m_sel  != 0) ? 32'd1 : 32'd0;
        else if (a == 8'hF8) return 32'(m_data);
        else                 return 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (!done) begin
            if (addr == 8'hF0)      chk("R2 lock read",    rdata, model_rd(addr));
            else if (addr == 8'hF4) chk("R4 select read",  rdata, model_rd(addr));
            else if (addr == 8'hF8) chk("R5 data read",    rdata, model_rd(addr));
            else                    chk("R8 unmapped read", rdata, model_rd(addr));
            chk("R4 strap word", 32'(strap_word),
                32'((m_sel != 0) ? 14'(m_data) : DEF));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk); addr = a; wr_en = 1'b0;
        #1 chk(tag, rdata, exp);
    endtask

    task automatic pulse_warm();
        @(negedge clk); warm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        warm_rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_rsm();
        @(negedge clk); rsm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rsm_rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        warm_rst_n = 1'b0; rsm_rst_n = 1'b0;
        addr = 8'h00; wr_en = 1'b0; wdata = '0;
        // R10: writes while both resets are held
        repeat (2) @(negedge clk);
        addr = 8'hF8; wdata = 32'h0000_1111; wr_en = 1'b1;
        @(negedge clk); addr = 8'hF4; wdata = 32'h1;
        @(negedge clk);
        // R10: write on the first edge after release
        warm_rst_n = 1'b1; rsm_rst_n = 1'b1;
        addr = 8'hF8; wdata = 32'h0000_0777; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rd("R10 data dropped in reset", 8'hF8, 32'h0);
        rd("R10 select dropped in reset", 8'hF4, 32'h0);

        // R1: reset state
        rd("R1 lock reset", 8'hF0, 32'h0);
        rd("R1 ctrl reset", 8'hF4, 32'h0);
        rd("R1 data reset", 8'hF8, 32'h0);
        chk("R1 default word", 32'(strap_word), 32'(DEF));

        // R8: unmapped reads and writes
        rd("R8 read 0x00", 8'h00, 32'h0);
        rd("R8 read 0xF1", 8'hF1, 32'h0);
        wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'hF1, 32'hFFFF_FFFF);
        rd("R8 read 0xFC", 8'hFC, 32'h0);
        rd("R8 no alias lock", 8'hF0, 32'h0);
        rd("R8 no alias ctrl", 8'hF4, 32'h0);
        rd("R8 no alias data", 8'hF8, 32'h0);

        // R9: strobe low
        @(negedge clk); addr = 8'hF8; wdata = 32'h0000_2222; wr_en = 1'b0;
        @(negedge clk); addr = 8'hF4; wdata = 32'h1;
        rd("R9 data unchanged", 8'hF8, 32'h0);
        rd("R9 ctrl unchanged", 8'hF4, 32'h0);

        // R5: reserved bits
        wr(8'hF8, 32'hFFFF_FFFF);
        rd("R5 data width", 8'hF8, 32'h0000_3FFF);
        wr(8'hF0, 32'hFFFF_FFFE);
        rd("R5 lock reserved", 8'hF0, 32'h0);
        wr(8'hF4, 32'hFFFF_FFFE);
        rd("R5 ctrl reserved", 8'hF4, 32'h0);
        chk("R4 default while select clear", 32'(strap_word), 32'(DEF));

        // R4: select
        wr(8'hF8, 32'h0000_1234);
        wr(8'hF4, 32'h1);
        #1 chk("R4 programmed word", 32'(strap_word), 32'h1234);
        wr(8'hF4, 32'h0);
        #1 chk("R4 back to default", 32'(strap_word), 32'(DEF));
        wr(8'hF4, 32'h1);

        // R2 / R3: seal and attempt changes
        wr(8'hF0, 32'h1);
        rd("R2 lock set", 8'hF0, 32'h1);
        wr(8'hF8, 32'h0000_2AAA);
        wr(8'hF4, 32'h0);
        wr(8'hF0, 32'h0);
        rd("R3 lock not clearable", 8'hF0, 32'h1);
        rd("R3 ctrl frozen", 8'hF4, 32'h1);
        rd("R3 data frozen", 8'hF8, 32'h0000_1234);
        #1 chk("R3 word frozen", 32'(strap_word), 32'h1234);

        // R6: warm reset clears lock only
        pulse_warm();
        rd("R6 lock cleared", 8'hF0, 32'h0);
        rd("R6 ctrl kept", 8'hF4, 32'h1);
        rd("R6 data kept", 8'hF8, 32'h0000_1234);
        #1 chk("R6 word kept", 32'(strap_word), 32'h1234);

        // R7: resume reset under lock
        wr(8'hF0, 32'h1);
        pulse_rsm();
        rd("R7 lock kept", 8'hF0, 32'h1);
        rd("R7 ctrl cleared", 8'hF4, 32'h0);
        rd("R7 data cleared", 8'hF8, 32'h0);
        #1 chk("R7 word default", 32'(strap_word), 32'(DEF));
        wr(8'hF8, 32'h0000_0155);
        wr(8'hF4, 32'h1);
        rd("R7 data still locked", 8'hF8, 32'h0);
        rd("R7 ctrl still locked", 8'hF4, 32'h0);
        pulse_warm();
        wr(8'hF8, 32'h0000_0155);
        rd("R7 writable after warm reset", 8'hF8, 32'h0000_0155);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errs++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule